// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks the line reservations that one processor makes with load-linked accesses. It decides whether each store-conditional succeeds. When a memory access completes, the surrounding request sequencer presents the access kind, its line address and whether the line's tag is present in the cache. One cycle later the block answers with a success bit. A load-linked reserves its line. A store-conditional succeeds only when its line is still reserved, and it drops the reservation in either case. Any other write-class completion to a present, reserved line breaks the reservation. The coherence side can also send a loss-of-permission notice for a line. When a store-conditional to that line is pending, the notice removes the reservation.

Reservations live in a small fully associative table of `DEPTH` entries. Each entry holds a valid bit, a line address and an age rank. When the table is full, a new load-linked evicts the oldest reservation. A locked read-modify-write read asks the sequencer to hold its request queue for that line, and the matching locked write releases it. This is tracked by a two-state controller. State `QS_OPEN` (queue flowing) moves to `QS_HELD` on the transition *lock-read*. `QS_HELD` returns to `QS_OPEN` on the transition *lock-write*. A lock-read while held stays in `QS_HELD` and retargets the line. A test mode bypasses the reservation logic, and every completion then reports success.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked completion (kind 3) always reports success and leaves its line reserved.
- R2: A store-conditional (kind 4) reports rsp_ok=1 if its line was reserved before that cycle, and rsp_ok=0 if it was not.
- R3: Every store-conditional removes the reservation on its line, whether it succeeded or failed.
- R4: A store (2), flush (7), locked read (5) or locked write (6) with cmp_tag_present=1 removes a reservation on its line. With cmp_tag_present=0 the reservation stays.
- R5: A loss notice with loss_sc_pending=1 removes the reservation on loss_line. With loss_sc_pending=0 the notice has no effect.
- R6: Load (0) and instruction fetch (1) completions report success and leave every reservation unchanged.
- R7: A locked read (5) pulses q_block for one cycle, sets q_blocked and presents its line on q_line. A locked write (6) pulses q_unblock, clears q_blocked and presents its line.
- R8: With test_mode=1, every completion reports success and no completion changes any reservation.
- R9: The table holds up to DEPTH lines. A load-linked to a new line when the table is full evicts the line that was reserved longest ago.
- R10: rsp_valid, rsp_ok, q_block and q_unblock are registered one cycle after cmp_valid. All outputs are 0 after reset.
- R11: When a loss notice arrives in the same cycle as a completion, the store-conditional outcome uses the state before that cycle. A load-linked in that cycle is applied after the notice's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Bypass reservation logic; all completions succeed |
| cmp_valid | input | 1 | Completion strobe |
| cmp_kind | input | 3 | Completion kind (0 load, 1 ifetch, 2 store, 3 LL, 4 SC, 5 locked read, 6 locked write, 7 flush) |
| cmp_line | input | LW | Line address of the completion |
| cmp_tag_present | input | 1 | Line's tag is present in the cache |
| loss_valid | input | 1 | Loss-of-permission notice strobe |
| loss_line | input | LW | Line losing permission |
| loss_sc_pending | input | 1 | A store-conditional to loss_line is pending |
| rsp_valid | output | 1 | Response valid, one cycle after cmp_valid |
| rsp_ok | output | 1 | Success bit of the response |
| q_block | output | 1 | Pulse: hold the request queue for q_line |
| q_unblock | output | 1 | Pulse: release the request queue for q_line |
| q_blocked | output | 1 | Queue controller is in QS_HELD |
| q_line | output | LW | Line of the latest block or unblock command |

## Verification
The bench goes after the reservation corner cases. A failed store-conditional must still clear its line; a design that kept it would let a later one succeed. A store to a line whose tag is absent must not clear the reservation; a design that ignored the presence input would fail the following store-conditional. Capacity eviction must drop the oldest line, not an arbitrary one. A slot chooser that picked by index would break a younger reservation and let the oldest survive. Same-cycle loss notices check two rules: a store-conditional must be judged on pre-cycle state, and a load-linked must re-reserve after the clear. Test mode must neither fail a store-conditional nor leave a load-linked behind.

// File: rtl/llsc_mon_pkg.sv
package llsc_mon_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_IFETCH  = 3'd1,
        OP_STORE   = 3'd2,
        OP_LL      = 3'd3,
        OP_SC      = 3'd4,
        OP_LOCK_RD = 3'd5,
        OP_LOCK_WR = 3'd6,
        OP_FLUSH   = 3'd7
    } op_kind_e;

    typedef enum logic {
        QS_OPEN = 1'b0,
        QS_HELD = 1'b1
    } qstate_e;

    function automatic logic is_store_class(op_kind_e k);
        return (k == OP_STORE) || (k == OP_LOCK_RD) ||
               (k == OP_LOCK_WR) || (k == OP_FLUSH);
    endfunction

endpackage

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
    parameter int DEPTH = 4,
    parameter int LW    = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] look_line,
    output logic          look_hit,
    input  logic          clr_look,
    input  logic          set_look,
    input  logic          clr_loss,
    input  logic [LW-1:0] loss_line
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] valid_q, valid_d;
    logic [LW-1:0]    line_q [DEPTH];
    logic [LW-1:0]    line_d [DEPTH];
    logic [AW-1:0]    age_q  [DEPTH];
    logic [AW-1:0]    age_d  [DEPTH];
    logic [AW-1:0]    age_adj[DEPTH];
    logic [DEPTH-1:0] m_look, m_loss, kill, keep;
    logic [CW-1:0]    live;
    logic             full, ins;
    logic [AW-1:0]    slot;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            m_look[i] = valid_q[i] && (line_q[i] == look_line);
            m_loss[i] = valid_q[i] && (line_q[i] == loss_line);
        end
        kill = ({DEPTH{clr_look}} & m_look) | ({DEPTH{clr_loss}} & m_loss);
        keep = valid_q & ~kill;

        live = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) live = live + CW'(1);
        end

        // Close the rank gaps left by cleared entries
        for (int i = 0; i < DEPTH; i++) begin
            age_adj[i] = age_q[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (kill[j] && (age_q[j] < age_q[i])) age_adj[i] = age_adj[i] - AW'(1);
            end
        end

        full = (live == CW'(DEPTH));
        ins  = set_look && !(|(keep & m_look));

        slot = '0;
        if (full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (age_adj[i] == AW'(DEPTH - 1)) slot = AW'(i);
            end
        end else begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (!keep[i]) slot = AW'(i);
            end
        end

        valid_d = keep;
        for (int i = 0; i < DEPTH; i++) begin
            line_d[i] = line_q[i];
            age_d[i]  = age_adj[i];
        end
        if (ins) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (keep[i] && (AW'(i) != slot)) age_d[i] = age_adj[i] + AW'(1);
            end
            valid_d[slot] = 1'b1;
            line_d[slot]  = look_line;
            age_d[slot]   = '0;
        end
    end

    assign look_hit = |m_look;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
                age_q[i]  <= '0;
            end
        end else begin
            valid_q <= valid_d;
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= line_d[i];
                age_q[i]  <= age_d[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_rank_chk
            AST_AGE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
                valid_q[g] |-> (int'(age_q[g]) < $countones(valid_q))); // R9
        end
    endgenerate

    AST_LL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        set_look |=> (valid_q != '0)); // R1

    AST_CLR_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_look && look_hit && !set_look) |=>
        ($countones(valid_q) < $past($countones(valid_q)))); // R3

endmodule

// File: rtl/llsc_queue_ctl.sv
module llsc_queue_ctl
    import llsc_mon_pkg::*;
#(
    parameter int LW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_rd,
    input  logic          lock_wr,
    input  logic [LW-1:0] line,
    output logic          q_block,
    output logic          q_unblock,
    output logic          q_blocked,
    output logic [LW-1:0] q_line
);
    qstate_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            QS_OPEN: if (lock_rd) st_d = QS_HELD;
            QS_HELD: if (lock_wr) st_d = QS_OPEN;
            default: st_d = QS_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= QS_OPEN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_block   <= 1'b0;
            q_unblock <= 1'b0;
            q_line    <= '0;
        end else begin
            q_block   <= lock_rd;
            q_unblock <= lock_wr;
            if (lock_rd || lock_wr) q_line <= line;
        end
    end

    assign q_blocked = (st_q == QS_HELD);

    AST_BLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        q_block |-> q_blocked); // R7

    AST_UNBLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        q_unblock |-> !q_blocked); // R7

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_mon_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LW    = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic          cmp_valid,
    input  logic [2:0]    cmp_kind,
    input  logic [LW-1:0] cmp_line,
    input  logic          cmp_tag_present,
    input  logic          loss_valid,
    input  logic [LW-1:0] loss_line,
    input  logic          loss_sc_pending,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic          q_block,
    output logic          q_unblock,
    output logic          q_blocked,
    output logic [LW-1:0] q_line
);
    op_kind_e kind;
    logic     hit, clr_cmp, set_ll, clr_loss, lrd, lwr, ok_d;

    assign kind = op_kind_e'(cmp_kind);

    always_comb begin
        clr_cmp  = cmp_valid && !test_mode &&
                   ((kind == OP_SC) || (is_store_class(kind) && cmp_tag_present));
        set_ll   = cmp_valid && !test_mode && (kind == OP_LL);
        clr_loss = loss_valid && loss_sc_pending;
        lrd      = cmp_valid && (kind == OP_LOCK_RD);
        lwr      = cmp_valid && (kind == OP_LOCK_WR);
        ok_d     = test_mode || (kind != OP_SC) || hit;
    end

    llsc_resv_table #(.DEPTH(DEPTH), .LW(LW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_line(cmp_line),
        .look_hit (hit),
        .clr_look (clr_cmp),
        .set_look (set_ll),
        .clr_loss (clr_loss),
        .loss_line(loss_line)
    );

    llsc_queue_ctl #(.LW(LW)) u_qctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_rd  (lrd),
        .lock_wr  (lwr),
        .line     (cmp_line),
        .q_block  (q_block),
        .q_unblock(q_unblock),
        .q_blocked(q_blocked),
        .q_line   (q_line)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= cmp_valid;
            rsp_ok    <= cmp_valid && ok_d;
        end
    end

    AST_RSP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> rsp_valid); // R10

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !rsp_valid); // R10

    AST_LL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && kind == OP_LL) |=> rsp_ok); // R1

    AST_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (kind == OP_LOAD || kind == OP_IFETCH)) |=> rsp_ok); // R6

    AST_TEST_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && test_mode) |=> rsp_ok); // R8

    AST_SC_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && kind == OP_SC && !test_mode && !hit) |=> !rsp_ok); // R2

endmodule

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
    localparam int DEPTH = 4;
    localparam int LW    = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0, cmp_valid = 1'b0, cmp_tag_present = 1'b0;
    logic [2:0]    cmp_kind = '0;
    logic [LW-1:0] cmp_line = '0, loss_line = '0;
    logic          loss_valid = 1'b0, loss_sc_pending = 1'b0;
    logic          rsp_valid, rsp_ok, q_block, q_unblock, q_blocked;
    logic [LW-1:0] q_line;

    always #2.5 clk = ~clk;

    llsc_monitor #(.DEPTH(DEPTH), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_line(cmp_line),
        .cmp_tag_present(cmp_tag_present), .loss_valid(loss_valid),
        .loss_line(loss_line), .loss_sc_pending(loss_sc_pending),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .q_block(q_block),
        .q_unblock(q_unblock), .q_blocked(q_blocked), .q_line(q_line)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [LW-1:0] mq[$];
    logic          m_blk = 0;
    logic [LW-1:0] m_qline = '0;

    function automatic int find(logic [LW-1:0] ln);
        for (int i = 0; i < mq.size(); i++) if (mq[i] == ln) return i;
        return -1;
    endfunction

    function automatic void drop(logic [LW-1:0] ln);
        int ix = find(ln);
        if (ix >= 0) mq.delete(ix);
    endfunction

    task automatic chk(string tag, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic v, logic [2:0] k, logic [LW-1:0] ln, logic pres,
                       logic lv, logic [LW-1:0] lln, logic lp, logic tm);
        logic e_ok, e_blk, e_unb;
        cmp_valid = v; cmp_kind = k; cmp_line = ln; cmp_tag_present = pres;
        loss_valid = lv; loss_line = lln; loss_sc_pending = lp; test_mode = tm;
        e_ok  = v && (tm || k != 3'd4 || find(ln) >= 0);
        e_blk = v && k == 3'd5;
        e_unb = v && k == 3'd6;
        if (e_blk) m_blk = 1;
        if (e_unb) m_blk = 0;
        if (e_blk || e_unb) m_qline = ln;
        if (lv && lp) drop(lln);
        if (v && !tm) begin
            if (k == 3'd4 || ((k == 3'd2 || k == 3'd5 || k == 3'd6 || k == 3'd7) && pres)) drop(ln);
            if (k == 3'd3 && find(ln) < 0) begin
                if (mq.size() == DEPTH) void'(mq.pop_front());
                mq.push_back(ln);
            end
        end
        @(negedge clk);
        chk(tag, "rsp_valid", LW'(rsp_valid), LW'(v));
        if (v) chk(tag, "rsp_ok", LW'(rsp_ok), LW'(e_ok));
        chk(tag, "q_block", LW'(q_block), LW'(e_blk));
        chk(tag, "q_unblock", LW'(q_unblock), LW'(e_unb));
        chk(tag, "q_blocked", LW'(q_blocked), LW'(m_blk));
        if (m_blk || e_unb) chk(tag, "q_line", q_line, m_qline);
    endtask

    task automatic op(string tag, logic [2:0] k, logic [LW-1:0] ln, logic pres);
        cyc(tag, 1, k, ln, pres, 0, '0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] a, b;
        void'($urandom(32'h5eed_1234));
        a = LW'(5); b = LW'(9);
        repeat (3) @(negedge clk);
        chk("R10", "reset rsp_valid", LW'(rsp_valid), '0);
        chk("R10", "reset q_block", LW'(q_block | q_unblock), '0);
        chk("R10", "reset q_blocked", LW'(q_blocked), '0);
        rst_n = 1;
        cyc("R10", 0, 3'd0, '0, 0, 0, '0, 0, 0);
        op("R1", 3'd3, a, 1);  op("R2", 3'd4, a, 1);
        op("R3", 3'd4, a, 1);
        op("R1", 3'd3, a, 1);  op("R6", 3'd0, a, 1); op("R6", 3'd1, a, 1);
        op("R6", 3'd4, a, 1);
        op("R1", 3'd3, a, 1);  op("R4", 3'd2, a, 0); op("R4", 3'd4, a, 1);
        op("R1", 3'd3, a, 1);  op("R4", 3'd2, a, 1); op("R4", 3'd4, a, 1);
        op("R1", 3'd3, a, 1);  op("R4", 3'd7, a, 1); op("R4", 3'd4, a, 1);
        op("R1", 3'd3, a, 1);
        cyc("R5", 0, 3'd0, '0, 0, 1, a, 0, 0); op("R5", 3'd4, a, 1);
        op("R1", 3'd3, a, 1);
        cyc("R5", 0, 3'd0, '0, 0, 1, a, 1, 0); op("R5", 3'd4, a, 1);
        for (int i = 0; i <= DEPTH; i++) op("R9", 3'd3, LW'(20 + i), 1);
        op("R9", 3'd4, LW'(20), 1); op("R9", 3'd4, LW'(21), 1);
        op("R9", 3'd4, LW'(20 + DEPTH), 1);
        cyc("R8", 1, 3'd4, b, 1, 0, '0, 0, 1);
        cyc("R8", 1, 3'd3, b, 1, 0, '0, 0, 1);
        op("R8", 3'd4, b, 1);
        op("R7", 3'd5, a, 1); op("R7", 3'd0, b, 1); op("R7", 3'd6, a, 1);
        op("R7", 3'd5, b, 1); op("R7", 3'd5, a, 1); op("R7", 3'd6, a, 1);
        op("R1", 3'd3, a, 1);
        cyc("R11", 1, 3'd4, a, 1, 1, a, 1, 0); op("R11", 3'd4, a, 1);
        op("R1", 3'd3, b, 1);
        cyc("R11", 1, 3'd3, b, 1, 1, b, 1, 0); op("R11", 3'd4, b, 1);
        for (int n = 0; n < 4000; n++) begin
            cyc("R10 rand", ($urandom % 4) != 0, 3'($urandom % 8), LW'(8 + $urandom % 6),
                1'($urandom % 2), ($urandom % 5) == 0, LW'(8 + $urandom % 6),
                1'($urandom % 2), ($urandom % 16) == 0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule